// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two independent count channels. They share one byte that selects their modes and one control byte that holds the run bits and overflow flags. Each channel keeps its count in a low byte and a high byte. A channel advances once per machine cycle when it acts as a timer. When it acts as a counter, it advances on each falling edge of its external count pin. A gate pin can hold the channel off while the pin is low.

Four layouts are selectable per channel:
- a 13-bit count, with 5 bits held in the low byte;
- a full 16-bit count;
- an 8-bit count that reloads from the high byte;
- a split layout. On channel 0 it makes two free 8-bit counters. On channel 1 it freezes the channel.

Software reads and writes every register through a byte-wide port. Each channel's overflow flag is also brought out as a level for an interrupt controller. The controller can clear the flag with a one-cycle acknowledge.

Top module: `dual_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0x00 and both `ovf` bits are 0.
- R2: Register addresses are as follows:

  | Address | Register |
  |---------|----------|
  | 0 | mode |
  | 1 | control |
  | 2 | ch0 low byte |
  | 3 | ch0 high byte |
  | 4 | ch1 low byte |
  | 5 | ch1 high byte |

  `rd_data` shows the register addressed in the previous cycle. In the mode byte, bits 7:4 set channel 1 and bits 3:0 set channel 0. Each nibble holds gate enable (bit 3), counter select (bit 2) and layout (bits 1:0). In the control byte, bit 7 is ch1 flag, bit 6 is ch1 run, bit 5 is ch0 flag and bit 4 is ch0 run. Bits 3:0 are plain storage.
- R3: Layout 00 is a 13-bit count. The high byte holds bits 12:5 and the low byte holds bits 4:0. Low-byte bits 7:5 always read 0, even after a write.
- R4: Layout 01 is a 16-bit count {high, low} that wraps from 0xFFFF to 0x0000.
- R5: Layout 10 increments the low byte. At 0xFF the low byte is loaded from the high byte, and the high byte is left unchanged.
- R6: With counter select 0, an enabled channel advances once per machine cycle (once per clock when MC_DIV = 1). With counter select 1, it advances once per falling edge of its synchronized count pin.
- R7: A channel whose run bit is 0 holds its count. With gate enable set, the channel also holds while its gate pin is low.
- R8: Layout 11 on channel 0 makes two 8-bit counters:
  - The low byte runs under ch0 run, gate and select, and sets the ch0 flag when it wraps.
  - The high byte counts machine cycles under ch1 run alone, and sets the ch1 flag when it wraps.
  - While this layout is active, channel 1 wraps do not set the ch1 flag.
- R9: Layout 11 on channel 1 freezes both of its bytes.
- R10: A flag sets on the clock edge at which its counter wraps, and it appears at `ovf` at once. The flag clears on `irq_ack` or on a control write of 0. A wrap wins over an acknowledge, and a control write wins over both.
- R11: A write to a count byte overrides any increment of that byte at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_addr | input | 3 | register select |
| reg_wr | input | 1 | write strobe |
| reg_wdata | input | 8 | write data |
| rd_data | output | 8 | registered read data |
| cnt_pin | input | 2 | external count inputs, one per channel |
| gate_pin | input | 2 | external gate inputs, one per channel |
| irq_ack | input | 2 | one-cycle flag clear, one per channel |
| ovf | output | 2 | overflow flags {ch1, ch0} |

## Verification
The in-line properties check on every cycle that:
- the 13-bit layout keeps the low byte's top bits clear;
- the reload takes the high byte;
- a stopped channel 0 or a frozen channel 1 holds its count;
- flags set on a wrap and clear on an acknowledge.

Only the bench scenarios can show the following:
- exact count values after many cycles in each layout;
- edge counting through the synchronizer;
- gate holding;
- the borrowed run bit and flag of the split layout;
- a write overriding an increment.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MD_13    = 2'b00,
    MD_16    = 2'b01,
    MD_RLD   = 2'b10,
    MD_SPLIT = 2'b11
  } tmr_mode_e;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/tmr_fall.sv
module tmr_fall #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] din,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst)       prev_q <= '0;
    else if (tick) prev_q <= din;
  end

  assign fall = {W{tick}} & prev_q & ~din;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  tmr_mode_e         mode,
  input  logic              inc_lo,
  input  logic              inc_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] tl,
  output logic [BYTE_W-1:0] th,
  output logic              wrap_lo,
  output logic              wrap_hi
);
  logic [BYTE_W-1:0] tl_n, th_n;
  logic [4:0]        lo5_inc;

  assign lo5_inc = tl[4:0] + 5'd1;

  always_comb begin
    tl_n    = tl;
    th_n    = th;
    wrap_lo = 1'b0;
    wrap_hi = 1'b0;
    case (mode)
      MD_13: if (inc_lo) begin
        tl_n = {3'b000, lo5_inc};
        if (tl[4:0] == 5'h1f) begin
          th_n    = th + 8'd1;
          wrap_lo = (th == 8'hff);
        end
      end
      MD_16: if (inc_lo) begin
        tl_n = tl + 8'd1;
        if (tl == 8'hff) begin
          th_n    = th + 8'd1;
          wrap_lo = (th == 8'hff);
        end
      end
      MD_RLD: if (inc_lo) begin
        if (tl == 8'hff) begin
          tl_n    = th;
          wrap_lo = 1'b1;
        end else begin
          tl_n = tl + 8'd1;
        end
      end
      default: begin
        if (inc_lo) begin
          tl_n    = tl + 8'd1;
          wrap_lo = (tl == 8'hff);
        end
        if (inc_hi) begin
          th_n    = th + 8'd1;
          wrap_hi = (th == 8'hff);
        end
      end
    endcase
    if (wr_lo) tl_n = (mode == MD_13) ? {3'b000, wdata[4:0]} : wdata;
    if (wr_hi) th_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tl <= '0;
      th <= '0;
    end else begin
      tl <= tl_n;
      th <= th_n;
    end
  end

  // R3: 13-bit layout never leaves low-byte top bits set after an advance
  a_r3_lo_top_clear: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_13 && inc_lo) |=> (tl[7:5] == 3'b000));

  // R5: reload layout copies the high byte at the low-byte wrap
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_RLD && inc_lo && tl == 8'hff && !wr_lo) |=> (tl == $past(th)));
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import tmr_pkg::*;
#(
  parameter int MC_DIV      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic [1:0]        irq_ack,
  output logic [1:0]        ovf
);
  localparam int NCH = 2;

  logic [BYTE_W-1:0] tmod_q, tcon_q;
  logic [BYTE_W-1:0] tl_q [NCH];
  logic [BYTE_W-1:0] th_q [NCH];
  logic [NCH-1:0]    tr, wr_lo, wr_hi, wrap_lo, wrap_hi;
  logic [NCH-1:0]    cnt_s, gate_s, fall;
  logic              tick, ctrl_wr, mode_wr, split0, set_tf0, set_tf1;

  // machine-cycle strobe
  if (MC_DIV > 1) begin : g_div
    localparam int DW = $clog2(MC_DIV);
    logic [DW-1:0] div_q;
    always_ff @(posedge clk) begin
      if (rst) div_q <= '0;
      else     div_q <= (div_q == DW'(MC_DIV - 1)) ? '0 : div_q + 1'b1;
    end
    assign tick = (div_q == DW'(MC_DIV - 1));
  end else begin : g_nodiv
    assign tick = 1'b1;
  end

  tmr_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync_cnt (
    .clk(clk), .rst(rst), .din(cnt_pin), .dout(cnt_s));
  tmr_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync_gate (
    .clk(clk), .rst(rst), .din(gate_pin), .dout(gate_s));
  tmr_fall #(.W(NCH)) u_fall (
    .clk(clk), .rst(rst), .tick(tick), .din(cnt_s), .fall(fall));

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign mode_wr = reg_wr && (reg_addr == A_MODE);
  assign split0  = (tmod_q[1:0] == 2'b11);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(A_LO0 + 2*c);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(A_LO0 + 2*c + 1);
    logic [3:0] nib;
    tmr_mode_e  md;
    logic       run, adv, inc_lo, inc_hi;

    assign nib      = tmod_q[4*c +: 4];
    assign md       = tmr_mode_e'(nib[1:0]);
    assign tr[c]    = tcon_q[4 + 2*c];
    assign run      = tr[c] & (~nib[3] | gate_s[c]);
    assign adv      = run & (nib[2] ? fall[c] : tick);
    assign wr_lo[c] = reg_wr && (reg_addr == LO_A);
    assign wr_hi[c] = reg_wr && (reg_addr == HI_A);

    if (c == 0) begin : g_lead
      assign inc_lo = adv;
      assign inc_hi = tick & tr[1] & (md == MD_SPLIT);
    end else begin : g_trail
      assign inc_lo = adv & (md != MD_SPLIT);
      assign inc_hi = 1'b0;
    end

    tmr_chan u_chan (
      .clk(clk), .rst(rst), .mode(md), .inc_lo(inc_lo), .inc_hi(inc_hi),
      .wr_lo(wr_lo[c]), .wr_hi(wr_hi[c]), .wdata(reg_wdata),
      .tl(tl_q[c]), .th(th_q[c]), .wrap_lo(wrap_lo[c]), .wrap_hi(wrap_hi[c]));
  end

  assign set_tf0 = wrap_lo[0];
  assign set_tf1 = split0 ? wrap_hi[0] : (wrap_lo[1] | wrap_hi[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmod_q <= '0;
      tcon_q <= '0;
    end else begin
      if (mode_wr) tmod_q <= reg_wdata;
      if (ctrl_wr) begin
        tcon_q <= reg_wdata;
      end else begin
        if (set_tf0)         tcon_q[5] <= 1'b1;
        else if (irq_ack[0]) tcon_q[5] <= 1'b0;
        if (set_tf1)         tcon_q[7] <= 1'b1;
        else if (irq_ack[1]) tcon_q[7] <= 1'b0;
      end
    end
  end

  assign ovf = {tcon_q[7], tcon_q[5]};

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (reg_addr)
        3'd0:    rd_data <= tmod_q;
        3'd1:    rd_data <= tcon_q;
        3'd2:    rd_data <= tl_q[0];
        3'd3:    rd_data <= th_q[0];
        3'd4:    rd_data <= tl_q[1];
        3'd5:    rd_data <= th_q[1];
        default: rd_data <= '0;
      endcase
    end
  end

  // R10: a wrap raises the flag at the next edge unless software writes control
  a_r10_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    (set_tf0 && !ctrl_wr) |=> ovf[0]);

  // R10: acknowledge clears the flag when no wrap coincides
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[0] && !set_tf0 && !ctrl_wr) |=> !ovf[0]);

  // R9: channel 1 frozen in layout 11
  a_r9_ch1_frozen: assert property (@(posedge clk) disable iff (rst)
    (tmod_q[5:4] == 2'b11 && !mode_wr && !wr_lo[1] && !wr_hi[1])
    |=> (tl_q[1] == $past(tl_q[1]) && th_q[1] == $past(th_q[1])));

  // R7: stopped channel 0 low byte holds
  a_r7_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!tr[0] && !wr_lo[0]) |=> (tl_q[0] == $past(tl_q[0])));
endmodule

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rd_data;
  logic [1:0] cnt_pin = '0, gate_pin = '0, irq_ack = '0;
  logic [1:0] ovf;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_timer u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .irq_ack(irq_ack), .ovf(ovf));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  // expected state after n advances; flag reflects the first n-1 advances
  task automatic ref_run(input logic [1:0] m, input logic [7:0] a, input logic [7:0] b,
                         input int n, output logic [7:0] ra, output logic [7:0] rb,
                         output logic f);
    logic [12:0] v13;
    logic [15:0] v16;
    logic        w;
    f = 1'b0; ra = (m == 2'd0) ? (a & 8'h1f) : a; rb = b;
    for (int i = 0; i < n; i++) begin
      w = 1'b0;
      case (m)
        2'd0: begin
          v13 = {rb, ra[4:0]};
          w = (v13 == 13'h1fff);
          v13 = v13 + 13'd1;
          rb = v13[12:5]; ra = {3'b000, v13[4:0]};
        end
        2'd1: begin
          v16 = {rb, ra};
          w = (v16 == 16'hffff);
          v16 = v16 + 16'd1;
          rb = v16[15:8]; ra = v16[7:0];
        end
        default: begin
          if (ra == 8'hff) begin ra = rb; w = 1'b1; end
          else ra = ra + 8'd1;
        end
      endcase
      if (w && i < n - 1) f = 1'b1;
    end
  endtask

  task automatic run_chk(input int ch, input logic [1:0] m, input logic [7:0] a,
                         input logic [7:0] b, input int n, input string tag);
    logic [7:0] ea, eb, v;
    logic       ef, fl;
    ref_run(m, a, b, n, ea, eb, ef);
    wr(3'd0, 8'({6'd0, m} << (4*ch)));
    wr(3'(2 + 2*ch), a);
    wr(3'(3 + 2*ch), b);
    wr(3'd1, 8'(8'h10 << (2*ch)));
    repeat (n - 1) @(negedge clk);
    fl = ovf[ch];
    wr(3'd1, 8'h00);
    rd(3'(2 + 2*ch), v); check({tag, " low"}, v, ea);
    rd(3'(3 + 2*ch), v); check({tag, " high"}, v, eb);
    check({tag, " R10 flag"}, {7'd0, fl}, {7'd0, ef});
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R1 reset reg", v, 8'h00);
    end
    check("R1 ovf", {6'd0, ovf}, 8'h00);

    // R2 readback of mode and control storage bits
    wr(3'd0, 8'hA4); rd(3'd0, v); check("R2 mode readback", v, 8'hA4);
    wr(3'd1, 8'h0A); rd(3'd1, v); check("R2 ctrl low nibble", v, 8'h0A);
    wr(3'd1, 8'h00);

    // R3 masked write in 13-bit layout
    wr(3'd0, 8'h00); wr(3'd2, 8'hFF); rd(3'd2, v); check("R3 masked write", v, 8'h1F);

    // directed layouts
    run_chk(0, 2'd0, 8'h1C, 8'hFF, 6, "R3");
    run_chk(1, 2'd1, 8'hFD, 8'hFF, 5, "R4");
    run_chk(0, 2'd2, 8'hFE, 8'h80, 3, "R5");

    // R6 random timer runs
    for (int k = 0; k < 30; k++) begin
      int ch, n;
      logic [1:0] m;
      logic [7:0] a, b;
      ch = int'($urandom % 2);
      m  = 2'($urandom % 3);
      a  = 8'($urandom);
      b  = 8'hFF - 8'($urandom % 3);
      n  = 1 + int'($urandom % 300);
      run_chk(ch, m, a, b, n, (m == 2'd0) ? "R3 R6" : (m == 2'd1) ? "R4 R6" : "R5 R6");
    end

    // R11 write beats increment
    wr(3'd0, 8'h01); wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    repeat (3) @(negedge clk);
    wr(3'd2, 8'h40);
    wr(3'd1, 8'h00);
    rd(3'd2, v); check("R11 write priority", v, 8'h41);

    // R7 gate low holds, gate high counts
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    gate_pin[0] = 1'b0; repeat (4) @(negedge clk);
    wr(3'd1, 8'h10); repeat (9) @(negedge clk); wr(3'd1, 8'h00);
    rd(3'd2, v); check("R7 gate low hold", v, 8'h00);
    gate_pin[0] = 1'b1; repeat (4) @(negedge clk);
    wr(3'd1, 8'h10); repeat (9) @(negedge clk); wr(3'd1, 8'h00);
    rd(3'd2, v); check("R7 gate high count", v, 8'h0A);
    gate_pin[0] = 1'b0;

    // R6 counter select counts falling edges
    wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    cnt_pin[0] = 1'b1; repeat (5) @(negedge clk);
    wr(3'd1, 8'h10);
    for (int p = 0; p < 7; p++) begin
      cnt_pin[0] = 1'b0; repeat (3) @(negedge clk);
      cnt_pin[0] = 1'b1; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    wr(3'd1, 8'h00);
    rd(3'd2, v); check("R6 edge count", v, 8'h07);

    // R8 split: high byte under ch1 run only, gate ignored
    wr(3'd0, 8'h0B); wr(3'd2, 8'h20); wr(3'd3, 8'hF0);
    gate_pin[0] = 1'b0;
    wr(3'd1, 8'h40);
    repeat (19) @(negedge clk);
    check("R8 split flags", {6'd0, ovf}, 8'h02);
    wr(3'd1, 8'h00);
    rd(3'd3, v); check("R8 split high", v, 8'h04);
    rd(3'd2, v); check("R8 split low held", v, 8'h20);

    // R9 channel 1 frozen
    wr(3'd0, 8'h30); wr(3'd4, 8'h55); wr(3'd5, 8'h66);
    wr(3'd1, 8'h40); repeat (9) @(negedge clk); wr(3'd1, 8'h00);
    rd(3'd4, v); check("R9 frozen low", v, 8'h55);
    rd(3'd5, v); check("R9 frozen high", v, 8'h66);

    // R10 acknowledge clears flag
    wr(3'd0, 8'h02); wr(3'd3, 8'h00); wr(3'd2, 8'hFE);
    wr(3'd1, 8'h10);
    repeat (2) @(negedge clk);
    check("R10 flag set", {7'd0, ovf[0]}, 8'h01);
    irq_ack[0] = 1'b1; @(negedge clk); irq_ack[0] = 1'b0;
    check("R10 ack clear", {7'd0, ovf[0]}, 8'h00);
    wr(3'd1, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule